// File: doc/BRIEF.md
# Host Bus Width and Word-Swap Adapter

This block joins a host data bus of 8, 16 or 32 bits to an internal 32-bit register port. It works out which internal byte lanes an access touches, sets the byte enables for byte, half-word and word accesses, and places the host data on those lanes. It can swap half-words internally but never swaps bytes. A narrow host therefore presents each byte replicated across its own lanes: an 8-bit host byte reaches every internal lane, and a 16-bit host half-word reaches both internal halves.

Two independent front ends, one synchronous and one asynchronous, issue requests and share the host data signals. Their transfers may alternate freely but never overlap. When both request in the same cycle, the synchronous side is granted first. A request that arrives while the other side is busy waits until that transfer has finished. An access that is wider than the bus allows, or that is misaligned, completes at once with an error and never reaches the internal port.

Top module: `host_bus_adapter`

## Requirements
- R1: After reset, reg_req_o, s_done_o, a_done_o and err_o are all low.
- R2: The size code is 0 = byte, 1 = half-word, 2 = word and 3 = reserved. Bit k of reg_be_o enables internal byte lane k, and address bits [1:0] give the byte offset. A byte access enables lane offset only. A half-word access enables lanes 3:2 when address bit 1 is set and lanes 1:0 otherwise. A word access enables all four lanes.
- R3: On writes, internal lane k carries host byte (k mod HOST_W/8). An 8-bit host byte is replicated on all four lanes, a 16-bit host half-word is replicated on both halves (the word swap), and a 32-bit host passes straight through.
- R4: A completed read returns the following on hd_rd_o:
  - on a 32-bit bus, the whole internal word;
  - on a 16-bit bus, the internal half selected by address bit 1;
  - on an 8-bit bus, the internal byte selected by address bits [1:0].
- R5: An access whose size exceeds the bus width (a half-word on an 8-bit bus, a word on an 8- or 16-bit bus) completes with err_o high alongside its done pulse. The reserved size code is treated the same way. No internal request is raised, so nothing is written.
- R6: A misaligned access completes with err_o and raises no internal request. This covers a half-word at an odd address and a word whose address bits [1:0] are not zero.
- R7: Once raised, reg_req_o stays high with reg_addr_o, reg_be_o, reg_we_o and reg_wdata_o unchanged until the cycle in which reg_ack_i is seen.
- R8: When both front ends request in the same idle cycle, the synchronous transfer is carried out and completed first.
- R9: A request from one front end that arrives while the other's transfer is in progress is held off, and is completed only after the current transfer has completed.
- R10: Each transfer ends with one single-cycle done pulse on the owning front end only. hd_rd_o is updated only when a read completes and holds its value through later writes.
- R11: reg_addr_o carries the host byte address shifted right by two (the word index).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_req_i | input | 1 | Synchronous front end request, held until done |
| s_we_i | input | 1 | Synchronous write (1) or read (0) |
| s_addr_i | input | ADDR_W | Synchronous byte address |
| s_size_i | input | 2 | Synchronous access size code |
| s_done_o | output | 1 | Synchronous transfer complete pulse |
| a_req_i | input | 1 | Asynchronous front end request, held until done |
| a_we_i | input | 1 | Asynchronous write (1) or read (0) |
| a_addr_i | input | ADDR_W | Asynchronous byte address |
| a_size_i | input | 2 | Asynchronous access size code |
| a_done_o | output | 1 | Asynchronous transfer complete pulse |
| hd_wr_i | input | HOST_W | Shared host write data |
| hd_rd_o | output | HOST_W | Read data for the host, held after a read |
| err_o | output | 1 | Access rejected, valid with done |
| reg_req_o | output | 1 | Internal port request |
| reg_we_o | output | 1 | Internal port write |
| reg_addr_o | output | ADDR_W-2 | Internal word index |
| reg_be_o | output | 4 | Internal byte enables |
| reg_wdata_o | output | 32 | Internal write data |
| reg_rdata_i | input | 32 | Internal read data |
| reg_ack_i | input | 1 | Internal port acknowledge |

## Verification
The bench builds three copies of the block, at HOST_W of 8, 16 and 32, all with ADDR_W of 6. Each copy runs against its own responder, which acknowledges after a fixed delay. Having all three widths brings byte replication, half-word swapping and the full-width pass-through within reach in one run. It also exercises every size-limit rejection: half-words on the 8-bit bus and words on the narrower buses. On the 16-bit copy, both front ends are raised together and overlapped, which shows the ordering of grants and the hold-off.

// File: rtl/hba_pkg.sv
package hba_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  typedef enum logic {
    OWN_SYNC  = 1'b0,
    OWN_ASYNC = 1'b1
  } owner_e;
endpackage

// File: rtl/hba_access_check.sv
module hba_access_check #(
  parameter int HOST_W = 16
) (
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  output logic       err_o
);
  import hba_pkg::*;

  localparam int LANES    = HOST_W / 8;
  localparam int MAX_SIZE = $clog2(LANES);

  logic too_wide;
  logic misaligned;

  always_comb begin
    too_wide   = (size_i == SZ_RSVD) || (int'(size_i) > MAX_SIZE);
    misaligned = 1'b0;
    case (size_e'(size_i))
      SZ_HALF: misaligned = addr_lo_i[0];
      SZ_WORD: misaligned = |addr_lo_i;
      default: misaligned = 1'b0;
    endcase
    err_o = too_wide || misaligned;
  end
endmodule

// File: rtl/hba_lane_map.sv
module hba_lane_map #(
  parameter int HOST_W = 16
) (
  input  logic [1:0]        size_i,
  input  logic [1:0]        addr_lo_i,
  input  logic [HOST_W-1:0] hd_wr_i,
  input  logic [31:0]       word_rd_i,
  output logic [3:0]        be_o,
  output logic [31:0]       wdata_o,
  output logic [HOST_W-1:0] hd_rd_o
);
  import hba_pkg::*;

  localparam int REP = 32 / HOST_W;

  always_comb begin
    case (size_e'(size_i))
      SZ_BYTE: be_o = 4'b0001 << addr_lo_i;
      SZ_HALF: be_o = addr_lo_i[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: be_o = 4'b1111;
      default: be_o = 4'b0000;
    endcase
  end

  // no byte swap: narrow host data is replicated across the internal word
  assign wdata_o = {REP{hd_wr_i}};

  generate
    if (HOST_W == 32) begin : g_rd32
      assign hd_rd_o = word_rd_i;
    end else if (HOST_W == 16) begin : g_rd16
      assign hd_rd_o = addr_lo_i[1] ? word_rd_i[31:16] : word_rd_i[15:0];
    end else begin : g_rd8
      always_comb begin
        case (addr_lo_i)
          2'd0:    hd_rd_o = word_rd_i[7:0];
          2'd1:    hd_rd_o = word_rd_i[15:8];
          2'd2:    hd_rd_o = word_rd_i[23:16];
          default: hd_rd_o = word_rd_i[31:24];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/hba_arbiter.sv
module hba_arbiter #(
  parameter int HOST_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_req_i,
  input  logic              s_we_i,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic [1:0]        s_size_i,
  input  logic              a_req_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [1:0]        a_size_i,
  input  logic [HOST_W-1:0] hd_wr_i,
  output logic [1:0]        sel_size_o,
  output logic [1:0]        sel_addr_lo_o,
  input  logic              chk_err_i,
  input  logic              reg_ack_i,
  input  logic [HOST_W-1:0] rd_mapped_i,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic [1:0]        lat_size_o,
  output logic              lat_we_o,
  output logic [HOST_W-1:0] lat_hd_o,
  output logic              busy_o,
  output logic              s_done_o,
  output logic              a_done_o,
  output logic              err_o,
  output logic [HOST_W-1:0] rd_o
);
  import hba_pkg::*;

  state_e            st_q;
  owner_e            own_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              we_q;
  logic [HOST_W-1:0] hd_q;
  logic [HOST_W-1:0] rd_q;

  logic              pick_sync;
  logic              grant;
  logic              sel_we;
  logic [ADDR_W-1:0] sel_addr;

  // fixed priority to the synchronous side
  assign pick_sync = s_req_i;
  assign grant     = (st_q == ST_IDLE) && (s_req_i || a_req_i);
  assign sel_we    = pick_sync ? s_we_i   : a_we_i;
  assign sel_addr  = pick_sync ? s_addr_i : a_addr_i;
  assign sel_size_o    = pick_sync ? s_size_i : a_size_i;
  assign sel_addr_lo_o = sel_addr[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      own_q  <= OWN_SYNC;
      err_q  <= 1'b0;
      addr_q <= '0;
      size_q <= '0;
      we_q   <= 1'b0;
      hd_q   <= '0;
      rd_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (grant) begin
            own_q  <= pick_sync ? OWN_SYNC : OWN_ASYNC;
            err_q  <= chk_err_i;
            addr_q <= sel_addr;
            size_q <= sel_size_o;
            we_q   <= sel_we;
            hd_q   <= hd_wr_i;
            st_q   <= chk_err_i ? ST_DONE : ST_XFER;
          end
        end
        ST_XFER: begin
          if (reg_ack_i) begin
            if (!we_q) rd_q <= rd_mapped_i;
            st_q <= ST_DONE;
          end
        end
        default: begin
          err_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
      endcase
    end
  end

  assign lat_addr_o = addr_q;
  assign lat_size_o = size_q;
  assign lat_we_o   = we_q;
  assign lat_hd_o   = hd_q;
  assign busy_o     = (st_q == ST_XFER);
  assign s_done_o   = (st_q == ST_DONE) && (own_q == OWN_SYNC);
  assign a_done_o   = (st_q == ST_DONE) && (own_q == OWN_ASYNC);
  assign err_o      = (st_q == ST_DONE) && err_q;
  assign rd_o       = rd_q;

  a_r5_err_skips_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && grant && chk_err_i) |=> (err_o && !busy_o));

  a_r8_sync_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && s_req_i && a_req_i) |=> (own_q == OWN_SYNC));

  a_r9_owner_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !reg_ack_i) |=> ($stable(own_q) && busy_o));

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_done_o || a_done_o) |=> !(s_done_o || a_done_o));
endmodule

// File: rtl/host_bus_adapter.sv
module host_bus_adapter #(
  parameter int HOST_W = 16,
  parameter int ADDR_W = 6,
  localparam int WADDR_W = ADDR_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               s_req_i,
  input  logic               s_we_i,
  input  logic [ADDR_W-1:0]  s_addr_i,
  input  logic [1:0]         s_size_i,
  output logic               s_done_o,
  input  logic               a_req_i,
  input  logic               a_we_i,
  input  logic [ADDR_W-1:0]  a_addr_i,
  input  logic [1:0]         a_size_i,
  output logic               a_done_o,
  input  logic [HOST_W-1:0]  hd_wr_i,
  output logic [HOST_W-1:0]  hd_rd_o,
  output logic               err_o,
  output logic               reg_req_o,
  output logic               reg_we_o,
  output logic [WADDR_W-1:0] reg_addr_o,
  output logic [3:0]         reg_be_o,
  output logic [31:0]        reg_wdata_o,
  input  logic [31:0]        reg_rdata_i,
  input  logic               reg_ack_i
);
  logic [1:0]        sel_size;
  logic [1:0]        sel_addr_lo;
  logic              chk_err;
  logic [ADDR_W-1:0] lat_addr;
  logic [1:0]        lat_size;
  logic              lat_we;
  logic [HOST_W-1:0] lat_hd;
  logic [HOST_W-1:0] rd_mapped;

  hba_access_check #(.HOST_W(HOST_W)) u_check (
    .size_i    (sel_size),
    .addr_lo_i (sel_addr_lo),
    .err_o     (chk_err)
  );

  hba_arbiter #(.HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .s_req_i       (s_req_i),
    .s_we_i        (s_we_i),
    .s_addr_i      (s_addr_i),
    .s_size_i      (s_size_i),
    .a_req_i       (a_req_i),
    .a_we_i        (a_we_i),
    .a_addr_i      (a_addr_i),
    .a_size_i      (a_size_i),
    .hd_wr_i       (hd_wr_i),
    .sel_size_o    (sel_size),
    .sel_addr_lo_o (sel_addr_lo),
    .chk_err_i     (chk_err),
    .reg_ack_i     (reg_ack_i),
    .rd_mapped_i   (rd_mapped),
    .lat_addr_o    (lat_addr),
    .lat_size_o    (lat_size),
    .lat_we_o      (lat_we),
    .lat_hd_o      (lat_hd),
    .busy_o        (reg_req_o),
    .s_done_o      (s_done_o),
    .a_done_o      (a_done_o),
    .err_o         (err_o),
    .rd_o          (hd_rd_o)
  );

  hba_lane_map #(.HOST_W(HOST_W)) u_lanes (
    .size_i    (lat_size),
    .addr_lo_i (lat_addr[1:0]),
    .hd_wr_i   (lat_hd),
    .word_rd_i (reg_rdata_i),
    .be_o      (reg_be_o),
    .wdata_o   (reg_wdata_o),
    .hd_rd_o   (rd_mapped)
  );

  assign reg_we_o   = lat_we;
  assign reg_addr_o = lat_addr[ADDR_W-1:2];

  a_r2_be_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> ($countones(reg_be_o) == (1 << lat_size)));

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_ack_i) |=>
      (reg_req_o && $stable(reg_addr_o) && $stable(reg_be_o) &&
       $stable(reg_wdata_o) && $stable(reg_we_o)));

  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_o && (s_done_o || a_done_o)));
endmodule

// File: tb/host_bus_adapter_bench.sv
module host_bus_adapter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic        s_req [3];
  logic        s_we  [3];
  logic [5:0]  s_addr[3];
  logic [1:0]  s_size[3];
  logic        a_req [3];
  logic        a_we  [3];
  logic [5:0]  a_addr[3];
  logic [1:0]  a_size[3];
  logic [31:0] hd_wr [3];
  logic        s_done[3];
  logic        a_done[3];
  logic        err   [3];
  logic        rreq  [3];
  logic        rwe   [3];
  logic [3:0]  raddr [3];
  logic [3:0]  rbe   [3];
  logic [31:0] rwd   [3];
  logic [31:0] hd_rd [3];
  logic [31:0] exp_mem [3][16];

  function automatic logic [31:0] seed_word(int w);
    return 32'hA1B2C3D4 ^ (w * 32'h01030507);
  endfunction

  for (genvar g = 0; g < 3; g++) begin : g_dut
    localparam int HW = 8 << g;
    logic [HW-1:0] rd_l;
    logic [31:0]   rmem [16];
    logic [31:0]   rdata;
    logic          ack;
    logic [1:0]    cnt;

    assign rdata    = rmem[raddr[g]];
    assign hd_rd[g] = 32'(rd_l);

    host_bus_adapter #(.HOST_W(HW), .ADDR_W(6)) u_host_bus_adapter (
      .clk_i(clk), .rst_ni(rst_n),
      .s_req_i(s_req[g]), .s_we_i(s_we[g]), .s_addr_i(s_addr[g]), .s_size_i(s_size[g]),
      .s_done_o(s_done[g]),
      .a_req_i(a_req[g]), .a_we_i(a_we[g]), .a_addr_i(a_addr[g]), .a_size_i(a_size[g]),
      .a_done_o(a_done[g]),
      .hd_wr_i(hd_wr[g][HW-1:0]), .hd_rd_o(rd_l), .err_o(err[g]),
      .reg_req_o(rreq[g]), .reg_we_o(rwe[g]), .reg_addr_o(raddr[g]), .reg_be_o(rbe[g]),
      .reg_wdata_o(rwd[g]), .reg_rdata_i(rdata), .reg_ack_i(ack)
    );

    initial for (int w = 0; w < 16; w++) rmem[w] = seed_word(w);

    always @(posedge clk) begin
      if (!rst_n) begin
        ack <= 1'b0;
        cnt <= 2'd0;
      end else begin
        ack <= 1'b0;
        if (rreq[g] && !ack) begin
          if (cnt == 2'd2) begin
            ack <= 1'b1;
            cnt <= 2'd0;
            if (rwe[g])
              for (int b = 0; b < 4; b++)
                if (rbe[g][b]) rmem[raddr[g]][8*b +: 8] <= rwd[g][8*b +: 8];
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int hw_of(int i);
    return 8 << i;
  endfunction

  function automatic logic [3:0] model_be(logic [1:0] size, logic [1:0] off);
    if (size == 2'd0) return 4'b0001 << off;
    if (size == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] model_wdata(int i, logic [31:0] d);
    int nb = hw_of(i) / 8;
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = d[8*(k % nb) +: 8];
    return r;
  endfunction

  function automatic bit model_err(int i, logic [1:0] size, logic [1:0] off);
    if (size == 2'd3) return 1'b1;
    if ((1 << size) > hw_of(i) / 8) return 1'b1;
    if (size == 2'd1 && off[0]) return 1'b1;
    if (size == 2'd2 && off != 2'd0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_rd(int i, logic [31:0] w, logic [1:0] off);
    if (hw_of(i) == 32) return w;
    if (hw_of(i) == 16) return off[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    return {24'h0, w[8*off +: 8]};
  endfunction

  // wait for a done pulse; checks the internal port each cycle against the model
  task automatic wait_done(int i, logic [3:0] e_addr, logic [3:0] e_be, logic [31:0] e_wd,
                           bit e_we, bit e_err, output bit saw_req);
    saw_req = 1'b0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (rreq[i]) begin
        saw_req = 1'b1;
        check(raddr[i] == e_addr, "R11 word index", 32'(raddr[i]), 32'(e_addr));
        check(rbe[i] == e_be, "R2 byte enable", 32'(rbe[i]), 32'(e_be));
        check(rwe[i] == e_we, "R7 write flag", 32'(rwe[i]), 32'(e_we));
        if (e_we) begin
          logic [31:0] m;
          for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{e_be[b]}};
          check((rwd[i] & m) == (e_wd & m), "R3 lane data", rwd[i] & m, e_wd & m);
        end
      end
      if (s_done[i] || a_done[i]) return;
    end
    check(1'b0, "R10 done missing", 0, 1);
  endtask

  task automatic xfer(int i, bit use_a, bit we, logic [5:0] addr, logic [1:0] size,
                      logic [31:0] data);
    bit e_err;
    bit saw;
    logic [3:0] e_be;
    logic [31:0] e_wd;
    logic [31:0] old_rd;
    e_err  = model_err(i, size, addr[1:0]);
    e_be   = model_be(size, addr[1:0]);
    e_wd   = model_wdata(i, data);
    old_rd = hd_rd[i];
    hd_wr[i] = data;
    if (use_a) begin
      a_req[i] = 1; a_we[i] = we; a_addr[i] = addr; a_size[i] = size;
    end else begin
      s_req[i] = 1; s_we[i] = we; s_addr[i] = addr; s_size[i] = size;
    end
    wait_done(i, addr[5:2], e_be, e_wd, we, e_err, saw);
    check(s_done[i] == !use_a && a_done[i] == use_a, "R10 done owner",
          {s_done[i], a_done[i]}, {!use_a, use_a});
    check(err[i] == e_err, e_err ? "R5/R6 error flag" : "R5 no error", 32'(err[i]), 32'(e_err));
    if (e_err) begin
      check(!saw, "R5 R6 no internal request", 32'(saw), 0);
    end else if (we) begin
      for (int b = 0; b < 4; b++)
        if (e_be[b]) exp_mem[i][addr[5:2]][8*b +: 8] = e_wd[8*b +: 8];
      check(hd_rd[i] == old_rd, "R10 read data held", hd_rd[i], old_rd);
    end else begin
      logic [31:0] er;
      er = model_rd(i, exp_mem[i][addr[5:2]], addr[1:0]);
      check(hd_rd[i] == er, "R4 read data", hd_rd[i], er);
    end
    if (use_a) a_req[i] = 0; else s_req[i] = 0;
    @(negedge clk);
    check(!s_done[i] && !a_done[i], "R10 single pulse", {s_done[i], a_done[i]}, 0);
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      s_req[i] = 0; s_we[i] = 0; s_addr[i] = 0; s_size[i] = 0;
      a_req[i] = 0; a_we[i] = 0; a_addr[i] = 0; a_size[i] = 0;
      hd_wr[i] = 0;
      for (int w = 0; w < 16; w++) exp_mem[i][w] = seed_word(w);
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++)
      check(!rreq[i] && !s_done[i] && !a_done[i] && !err[i], "R1 reset outputs",
            {rreq[i], s_done[i], a_done[i], err[i]}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 3; i++) begin
      // byte writes on every lane, then reads
      for (int o = 0; o < 4; o++)
        xfer(i, o[0], 1'b1, 6'(8 + o), 2'd0, 32'h11223344 + 32'(o) * 32'h10101010);
      for (int o = 0; o < 4; o++) xfer(i, 1'b0, 1'b0, 6'(8 + o), 2'd0, 0);
      // half-word on both halves: legal only on 16/32, R5 on 8
      xfer(i, 1'b0, 1'b1, 6'd18, 2'd1, 32'hCAFEBEEF);
      xfer(i, 1'b1, 1'b1, 6'd16, 2'd1, 32'h5A5A7E7E);
      xfer(i, 1'b0, 1'b0, 6'd18, 2'd1, 0);
      xfer(i, 1'b1, 1'b0, 6'd16, 2'd1, 0);
      // word: legal only on 32
      xfer(i, 1'b0, 1'b1, 6'd24, 2'd2, 32'h0BADF00D);
      xfer(i, 1'b0, 1'b0, 6'd24, 2'd2, 0);
      // R6 misaligned and reserved size
      xfer(i, 1'b0, 1'b1, 6'd33, 2'd1, 32'hFFFFFFFF);
      xfer(i, 1'b1, 1'b1, 6'd34, 2'd2, 32'hFFFFFFFF);
      xfer(i, 1'b0, 1'b1, 6'd36, 2'd3, 32'hFFFFFFFF);
      xfer(i, 1'b0, 1'b0, 6'd32, 2'd0, 0);
      xfer(i, 1'b0, 1'b0, 6'd33, 2'd0, 0);
    end

    // R8: simultaneous requests on the 16-bit copy
    begin
      int first;
      first = -1;
      hd_wr[1] = 32'h0000ABCD;
      s_req[1] = 1; s_we[1] = 1; s_addr[1] = 6'd40; s_size[1] = 2'd1;
      a_req[1] = 1; a_we[1] = 0; a_addr[1] = 6'd40; a_size[1] = 2'd1;
      for (int t = 0; t < 40 && first < 0; t++) begin
        @(negedge clk);
        if (s_done[1]) first = 0;
        else if (a_done[1]) first = 1;
      end
      check(first == 0, "R8 sync granted first", first, 0);
      exp_mem[1][10][15:0] = 16'hABCD;
      s_req[1] = 0;
      first = -1;
      for (int t = 0; t < 40 && first < 0; t++) begin
        @(negedge clk);
        if (a_done[1]) first = 1;
      end
      check(first == 1, "R8 async follows", first, 1);
      check(hd_rd[1] == 32'h0000ABCD, "R8 async sees sync write", hd_rd[1], 32'h0000ABCD);
      a_req[1] = 0;
      @(negedge clk);
    end

    // R9: async request raised while a sync transfer is in progress
    begin
      int order;
      order = 0;
      hd_wr[1] = 32'h00001357;
      s_req[1] = 1; s_we[1] = 1; s_addr[1] = 6'd42; s_size[1] = 2'd1;
      for (int t = 0; t < 40 && !rreq[1]; t++) @(negedge clk);
      a_req[1] = 1; a_we[1] = 0; a_addr[1] = 6'd42; a_size[1] = 2'd1;
      for (int t = 0; t < 40 && order == 0; t++) begin
        @(negedge clk);
        if (a_done[1]) order = 2;
        else if (s_done[1]) order = 1;
      end
      check(order == 1, "R9 held off until done", order, 1);
      exp_mem[1][10][31:16] = 16'h1357;
      s_req[1] = 0;
      order = 0;
      for (int t = 0; t < 40 && order == 0; t++) begin
        @(negedge clk);
        if (a_done[1]) order = 2;
      end
      check(order == 2, "R9 held request served", order, 2);
      check(hd_rd[1] == 32'h00001357, "R9 read after write", hd_rd[1], 32'h00001357);
      a_req[1] = 0;
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule